// File: doc/BRIEF.md
# Two-Channel HDLC Serial Framer

This block takes bytes from two independent byte streams, each offered through a valid/ready handshake. It turns them into one continuous bit-serial HDLC stream for a fixed-rate synchronous link. Every frame names its source stream in a one-byte address, carries a whole number of payload bytes, and ends with a 16-bit check sequence. Zero-bit stuffing keeps the payload from imitating a flag. Whenever neither stream has a byte to send, the block fills the link with back-to-back flag bytes, so the far end always sees a clocked stream and can drop the empty frames.

The link clock is shared with the block. A link bit-enable input says in which cycles the link takes a bit. One serial bit goes out per enabled cycle, together with a strobe. Stream 1 always wins when a new frame is about to open. A frame ends as soon as its stream has nothing more to offer, or when the payload limit is reached. An optional self-synchronising scrambler sits behind the framer and can be bypassed by an input.

Top module: `hdlc_dual_framer`

## Requirements
- R1: While reset is held, `ser_strobe`, `ser_out`, `s1_ready` and `s2_ready` are all 0.
- R2: With no stream valid, the serial output is an unbroken sequence of 0x7E bytes and contains no frame.
- R3: A frame is sent as an unstuffed 0x7E opening flag, then the address byte, then the payload bytes in the order accepted, then two check bytes, then an unstuffed 0x7E closing flag. Every byte is sent most significant bit first.
- R4: The address byte is 0x01 for a frame carrying stream 1 bytes and 0x02 for a frame carrying stream 2 bytes. One frame never mixes the two streams.
- R5: The check field is the CRC with polynomial 0x1021 (x^16+x^12+x^5+1), preset 0xFFFF, shifted MSB first over the address and payload bytes. It is sent bit-inverted, high byte first.
- R6: Between the flags, a 0 bit is inserted after every run of five 1 bits, so no run of more than six 1 bits ever appears on the line.
- R7: When both streams are valid while a new frame is being chosen, the frame opens with stream 1.
- R8: A frame closes when its stream is not valid at the next byte boundary, or once it carries MAX_INFO (default 1024) payload bytes. Remaining bytes go into later frames.
- R9: Exactly one serial bit is produced per cycle with `bit_en` high. It appears on `ser_out`, with `ser_strobe` high, in the following cycle.
- R10: A ready output rises only in a cycle with `bit_en` high, at most one of the two is high at a time, and neither stays high for two cycles in a row.
- R11: With `scr_bypass` low, each line bit is the framed bit XOR the line bits sent 18 and 23 positions earlier (register cleared at reset). With `scr_bypass` high, the framed bits go out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link and processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Link takes one bit in this cycle |
| scr_bypass | input | 1 | 1 = send framed bits unscrambled |
| s1_data | input | 8 | Stream 1 byte |
| s1_valid | input | 1 | Stream 1 byte available |
| s1_ready | output | 1 | Stream 1 byte accepted this cycle |
| s2_data | input | 8 | Stream 2 byte |
| s2_valid | input | 1 | Stream 2 byte available |
| s2_ready | output | 1 | Stream 2 byte accepted this cycle |
| ser_out | output | 1 | Serial line bit |
| ser_strobe | output | 1 | `ser_out` holds a new bit |

## Verification
The embedded properties assume that a source raising valid keeps its byte and its valid steady until ready takes the byte. The priority and frame-length properties also rely on this. The block itself only samples valid at byte boundaries. The bench source drivers change data and valid only on the falling clock edge, and only after a byte has been taken or a new burst has been queued, so they never withdraw an offered byte. The bench recovers frames by descrambling, watching for flags and removing stuffed zeros. It then checks address, payload, length and check bytes against its own CRC model.

// File: rtl/hdlc_fr_pkg.sv
`timescale 1ns/1ps
package hdlc_fr_pkg;
   localparam int unsigned   OCTET_W    = 8;
   localparam logic [7:0]    FLAG_BYTE  = 8'h7E;
   localparam logic [15:0]   FCS_PRESET = 16'hFFFF;
   localparam logic [15:0]   FCS_POLY   = 16'h1021;

   typedef enum logic [2:0] {
      FS_FLAG  = 3'd0,
      FS_ADDR  = 3'd1,
      FS_INFO  = 3'd2,
      FS_FCSH  = 3'd3,
      FS_FCSL  = 3'd4,
      FS_CLOSE = 3'd5
   } fr_state_e;

   // one byte of the check sequence, MSB first
   function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ FCS_POLY;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction
endpackage

// File: rtl/hdlc_byte_sched.sv
`timescale 1ns/1ps
module hdlc_byte_sched
   import hdlc_fr_pkg::*;
#(
   parameter int unsigned MAX_INFO = 1024,
   parameter logic [7:0]  ADDR_A   = 8'h01,
   parameter logic [7:0]  ADDR_B   = 8'h02
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic               take,
   input  logic [OCTET_W-1:0] a_data,
   input  logic               a_valid,
   output logic               a_ready,
   input  logic [OCTET_W-1:0] b_data,
   input  logic               b_valid,
   output logic               b_ready,
   output logic [OCTET_W-1:0] nxt_byte,
   output logic               nxt_stuff
);
   localparam int unsigned       CNT_W   = $clog2(MAX_INFO + 1);
   localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(MAX_INFO);

   if (MAX_INFO < 1) begin : g_bad_max
      $error("MAX_INFO must be at least 1");
   end
   if (ADDR_A == ADDR_B) begin : g_bad_addr
      $error("stream addresses must differ");
   end

   fr_state_e          state, state_n;
   logic               chan;        // 0 = stream 1, 1 = stream 2
   logic               cand;
   logic [15:0]        crc;
   logic [CNT_W-1:0]   info_cnt;
   logic               cur_valid, more, load_info;
   logic [OCTET_W-1:0] cur_data;

   always_comb begin
      cur_valid = chan ? b_valid : a_valid;
      cur_data  = chan ? b_data  : a_data;
      cand      = !a_valid;
      more      = cur_valid && (info_cnt < CNT_MAX);
      load_info = ((state == FS_ADDR) || (state == FS_INFO)) && more;
      state_n   = state;
      nxt_byte  = FLAG_BYTE;
      nxt_stuff = 1'b0;
      case (state)
         FS_FLAG: begin
            if (a_valid || b_valid) begin
               state_n   = FS_ADDR;
               nxt_byte  = a_valid ? ADDR_A : ADDR_B;
               nxt_stuff = 1'b1;
            end
         end
         FS_ADDR, FS_INFO: begin
            nxt_stuff = 1'b1;
            if (more) begin
               state_n  = FS_INFO;
               nxt_byte = cur_data;
            end else begin
               state_n  = FS_FCSH;
               nxt_byte = ~crc[15:8];
            end
         end
         FS_FCSH: begin
            state_n   = FS_FCSL;
            nxt_byte  = ~crc[7:0];
            nxt_stuff = 1'b1;
         end
         FS_FCSL: state_n = FS_CLOSE;
         default: state_n = FS_FLAG;
      endcase
      a_ready = take && load_info && !chan;
      b_ready = take && load_info &&  chan;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_FLAG;
         chan     <= 1'b0;
         crc      <= FCS_PRESET;
         info_cnt <= '0;
      end else if (take) begin
         state <= state_n;
         if ((state == FS_FLAG) && (state_n == FS_ADDR)) begin
            chan     <= cand;
            crc      <= fcs_step(FCS_PRESET, nxt_byte);
            info_cnt <= '0;
         end
         if (load_info) begin
            crc      <= fcs_step(crc, cur_data);
            info_cnt <= info_cnt + 1'b1;
         end
      end
   end

   p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_ready && b_ready));
   p_ready_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ready || b_ready) |-> bit_en);
   p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready |=> !a_ready);
   p_info_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      info_cnt <= CNT_MAX);
   p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_FLAG && take && a_valid) |=> (state == FS_ADDR && !chan));
endmodule

// File: rtl/hdlc_bit_shifter.sv
`timescale 1ns/1ps
module hdlc_bit_shifter
   import hdlc_fr_pkg::*;
#(
   parameter int unsigned RUN_MAX = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic [OCTET_W-1:0] nxt_byte,
   input  logic               nxt_stuff,
   output logic               take,
   output logic               raw_bit
);
   localparam int unsigned    BC_W  = $clog2(OCTET_W);
   localparam int unsigned    RUN_W = $clog2(RUN_MAX + 2);
   localparam logic [BC_W-1:0]  BC_LAST = BC_W'(OCTET_W - 1);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_MAX);

   if (RUN_MAX < 1) begin : g_bad_run
      $error("RUN_MAX must be at least 1");
   end

   logic [OCTET_W-1:0] sh;
   logic [BC_W-1:0]    bcnt;
   logic [RUN_W-1:0]   ones;
   logic               stuff_on, stuff_now;

   always_comb begin
      stuff_now = (ones == RUN_LIM);
      take      = bit_en && !stuff_now && (bcnt == BC_LAST);
      raw_bit   = stuff_now ? 1'b0 : sh[OCTET_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= FLAG_BYTE;
         bcnt     <= '0;
         ones     <= '0;
         stuff_on <= 1'b0;
      end else if (bit_en) begin
         if (stuff_now) begin
            ones <= '0;
         end else begin
            ones <= (stuff_on && sh[OCTET_W-1]) ? ones + 1'b1 : '0;
            if (bcnt == BC_LAST) begin
               sh       <= nxt_byte;
               stuff_on <= nxt_stuff;
               bcnt     <= '0;
            end else begin
               sh   <= {sh[OCTET_W-2:0], 1'b0};
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   p_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= RUN_LIM);
   p_run_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && ones == RUN_LIM) |=> (ones == '0));
   p_take_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> bit_en);
endmodule

// File: rtl/hdlc_line_scrambler.sv
`timescale 1ns/1ps
module hdlc_line_scrambler #(
   parameter bit          SCR_EN = 1'b1,
   parameter int unsigned TAP_A  = 18,
   parameter int unsigned TAP_B  = 23
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass,
   input  logic in_bit,
   input  logic in_vld,
   output logic out_bit,
   output logic out_stb
);
   logic sel_bit;

   if (SCR_EN) begin : g_scr
      if (TAP_A < 1 || TAP_A >= TAP_B) begin : g_bad_taps
         $error("scrambler taps need 1 <= TAP_A < TAP_B");
      end
      logic [TAP_B-1:0] hist;
      logic             scr;
      always_comb begin
         scr     = in_bit ^ hist[TAP_A-1] ^ hist[TAP_B-1];
         sel_bit = bypass ? in_bit : scr;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 hist <= '0;
         else if (in_vld && !bypass) hist <= {hist[TAP_B-2:0], scr};
      end
   end else begin : g_plain
      logic unused_bypass;
      always_comb begin
         sel_bit       = in_bit;
         unused_bypass = bypass;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bit <= 1'b0;
         out_stb <= 1'b0;
      end else begin
         out_bit <= in_vld ? sel_bit : 1'b0;
         out_stb <= in_vld;
      end
   end

   p_strobe_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_stb |-> $past(in_vld));
   p_quiet_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_stb |-> !out_bit);
endmodule

// File: rtl/hdlc_dual_framer.sv
`timescale 1ns/1ps
module hdlc_dual_framer
   import hdlc_fr_pkg::*;
#(
   parameter int unsigned MAX_INFO = 1024,
   parameter logic [7:0]  ADDR_S1  = 8'h01,
   parameter logic [7:0]  ADDR_S2  = 8'h02,
   parameter bit          SCR_EN   = 1'b1,
   parameter int unsigned TAP_A    = 18,
   parameter int unsigned TAP_B    = 23
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       scr_bypass,
   input  logic [7:0] s1_data,
   input  logic       s1_valid,
   output logic       s1_ready,
   input  logic [7:0] s2_data,
   input  logic       s2_valid,
   output logic       s2_ready,
   output logic       ser_out,
   output logic       ser_strobe
);
   logic               take, raw_bit, nxt_stuff;
   logic [OCTET_W-1:0] nxt_byte;

   hdlc_byte_sched #(
      .MAX_INFO (MAX_INFO),
      .ADDR_A   (ADDR_S1),
      .ADDR_B   (ADDR_S2)
   ) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .take      (take),
      .a_data    (s1_data),
      .a_valid   (s1_valid),
      .a_ready   (s1_ready),
      .b_data    (s2_data),
      .b_valid   (s2_valid),
      .b_ready   (s2_ready),
      .nxt_byte  (nxt_byte),
      .nxt_stuff (nxt_stuff)
   );

   hdlc_bit_shifter #(.RUN_MAX(5)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .nxt_byte  (nxt_byte),
      .nxt_stuff (nxt_stuff),
      .take      (take),
      .raw_bit   (raw_bit)
   );

   hdlc_line_scrambler #(
      .SCR_EN (SCR_EN),
      .TAP_A  (TAP_A),
      .TAP_B  (TAP_B)
   ) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .bypass  (scr_bypass),
      .in_bit  (raw_bit),
      .in_vld  (bit_en),
      .out_bit (ser_out),
      .out_stb (ser_strobe)
   );
endmodule

// File: tb/hdlc_dual_framer_bench.sv
`timescale 1ns/1ps
module hdlc_dual_framer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       scr_bypass = 1'b1;
   logic [7:0] s1_data = 8'h00, s2_data = 8'h00;
   logic       s1_valid = 1'b0, s2_valid = 1'b0;
   logic       s1_ready, s2_ready, ser_out, ser_strobe;

   always #2.5 clk = ~clk;

   hdlc_dual_framer u_hdlc_dual_framer (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .scr_bypass(scr_bypass),
      .s1_data(s1_data), .s1_valid(s1_valid), .s1_ready(s1_ready),
      .s2_data(s2_data), .s2_valid(s2_valid), .s2_ready(s2_ready),
      .ser_out(ser_out), .ser_strobe(ser_strobe)
   );

   int checks = 0, errors = 0;

   // source side
   logic [7:0] q1 [0:2047];
   logic [7:0] q2 [0:1023];
   int n1, n2, i1, i2, en_mode, cyc, en_cnt, xfer1, xfer2, rdy_viol;
   logic f1, f2, pr1, pr2;

   // line side
   logic       synced;
   logic [7:0] win, acc;
   int         ones, nb, flen, nfr, nflags, nstuff, maxrun, run, strobes, ndiff;
   logic [7:0] fb [0:1100];
   logic [7:0] fr_addr [0:31];
   int         fr_len [0:31];
   logic       fr_ok [0:31];
   logic [7:0] r1 [0:2047];
   logic [7:0] r2 [0:1023];
   int         nr1, nr2;
   logic [22:0] dh;

   function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] x;
      x = c;
      for (int k = 0; k < 8; k++) begin
         logic top;
         top = x[15] ^ d[7-k];
         x = {x[14:0], 1'b0};
         if (top) x = x ^ 16'h1021;
      end
      return x;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic end_frame();
      logic [15:0] c;
      int pl;
      if (flen < 3 || nfr >= 32) return;
      pl = flen - 3;
      c = 16'hFFFF;
      for (int k = 0; k < flen - 2; k++) c = bcrc(c, fb[k]);
      fr_addr[nfr] = fb[0];
      fr_len[nfr]  = pl;
      fr_ok[nfr]   = ({fb[flen-2], fb[flen-1]} == ~c);
      for (int k = 1; k <= pl; k++) begin
         if (fb[0] == 8'h01 && nr1 < 2048) begin r1[nr1] = fb[k]; nr1++; end
         else if (fb[0] == 8'h02 && nr2 < 1024) begin r2[nr2] = fb[k]; nr2++; end
      end
      nfr++;
   endtask

   // line monitor: samples registered outputs on the falling edge
   initial begin
      forever begin
         logic b, braw;
         @(negedge clk);
         if (rst_n && ser_strobe) begin
            braw = ser_out;
            if (!scr_bypass) begin
               b  = braw ^ dh[17] ^ dh[22];
               dh = {dh[21:0], braw};
            end else b = braw;
            if (b != braw) ndiff++;
            strobes++;
            run = b ? run + 1 : 0;
            if (run > maxrun) maxrun = run;
            win = {win[6:0], b};
            if (win == 8'h7E) begin
               nflags++;
               if (synced && flen > 0) end_frame();
               synced = 1'b1; flen = 0; nb = 0; ones = 0;
            end else if (synced) begin
               if (ones == 5 && !b) begin ones = 0; nstuff++; end
               else if (ones >= 5) ones = 6;
               else begin
                  acc = {acc[6:0], b};
                  nb++;
                  ones = b ? ones + 1 : 0;
                  if (nb == 8) begin
                     if (flen < 1101) fb[flen] = acc;
                     flen++;
                     nb = 0;
                  end
               end
            end
         end
      end
   end

   // source drivers and bit enable
   initial begin
      forever begin
         @(negedge clk);
         s1_valid = (i1 < n1);
         s1_data  = (i1 < 2048) ? q1[i1] : 8'h00;
         s2_valid = (i2 < n2);
         s2_data  = (i2 < 1024) ? q2[i2] : 8'h00;
         case (en_mode)
            0:       bit_en = 1'b0;
            1:       bit_en = 1'b1;
            default: bit_en = (cyc % 3 == 0);
         endcase
         cyc++;
         if (rst_n && bit_en) en_cnt++;
         #1;
         f1 = s1_valid && s1_ready;
         f2 = s2_valid && s2_ready;
         if ((s1_ready && pr1) || (s2_ready && pr2)) rdy_viol++;
         if ((s1_ready || s2_ready) && !bit_en) rdy_viol++;
         if (s1_ready && s2_ready) rdy_viol++;
         pr1 = s1_ready; pr2 = s2_ready;
         @(posedge clk);
         if (f1) begin i1++; xfer1++; end
         if (f2) begin i2++; xfer2++; end
      end
   end

   task automatic do_reset(input logic byp);
      @(negedge clk);
      rst_n = 1'b0; scr_bypass = byp; en_mode = 0;
      n1 = 0; n2 = 0; i1 = 0; i2 = 0; cyc = 0; en_cnt = 0;
      xfer1 = 0; xfer2 = 0; rdy_viol = 0; pr1 = 1'b0; pr2 = 1'b0;
      synced = 1'b0; win = 8'h00; acc = 8'h00; ones = 0; nb = 0; flen = 0;
      nfr = 0; nflags = 0; nstuff = 0; maxrun = 0; run = 0; strobes = 0;
      ndiff = 0; nr1 = 0; nr2 = 0; dh = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_frames(input int n, input int lim);
      for (int k = 0; k < lim && nfr < n; k++) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic chk_payload1(input string req);
      int bad = 0;
      for (int k = 0; k < n1; k++) if (k >= nr1 || r1[k] != q1[k]) bad++;
      chk(bad == 0 && nr1 == n1, req, "stream 1 payload bytes received", nr1, n1);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0; en_mode = 1;
      repeat (3) @(negedge clk);
      chk(ser_strobe == 1'b0, "R1", "strobe in reset", ser_strobe, 0);
      chk(ser_out == 1'b0, "R1", "line bit in reset", ser_out, 0);
      chk(!s1_ready && !s2_ready, "R1", "ready in reset", s1_ready | s2_ready, 0);
   endtask

   task automatic t_idle();
      do_reset(1'b1);
      en_mode = 1;
      repeat (400) @(negedge clk);
      en_mode = 0;
      repeat (4) @(negedge clk);
      chk(nfr == 0, "R2", "frames while idle", nfr, 0);
      chk(nflags >= 45, "R2", "idle flags seen", nflags, 45);
      chk(maxrun == 6, "R2", "longest ones run while idle", maxrun, 6);
   endtask

   task automatic t_single_s1();
      do_reset(1'b1);
      q1[0] = 8'hA5; q1[1] = 8'h3C; q1[2] = 8'h00;
      n1 = 3; en_mode = 1;
      wait_frames(1, 2000);
      chk(nfr >= 1 && fr_addr[0] == 8'h01, "R4", "stream 1 address", fr_addr[0], 1);
      chk(fr_len[0] == 3, "R8", "frame closes when stream empties", fr_len[0], 3);
      chk(fr_ok[0], "R5", "check field of stream 1 frame", fr_ok[0], 1);
      chk_payload1("R3");
   endtask

   task automatic t_single_s2();
      int bad = 0;
      do_reset(1'b1);
      for (int k = 0; k < 4; k++) q2[k] = 8'(8'h81 + k * 17);
      n2 = 4; en_mode = 1;
      wait_frames(1, 2000);
      chk(nfr >= 1 && fr_addr[0] == 8'h02, "R4", "stream 2 address", fr_addr[0], 2);
      for (int k = 0; k < 4; k++) if (k >= nr2 || r2[k] != q2[k]) bad++;
      chk(bad == 0 && nr2 == 4, "R3", "stream 2 payload bytes", nr2, 4);
      chk(fr_ok[0], "R5", "check field of stream 2 frame", fr_ok[0], 1);
   endtask

   task automatic t_priority();
      do_reset(1'b1);
      for (int k = 0; k < 5; k++) q1[k] = 8'(k + 1);
      for (int k = 0; k < 3; k++) q2[k] = 8'(8'hF0 + k);
      n1 = 5; n2 = 3; en_mode = 1;
      wait_frames(2, 4000);
      chk(nfr == 2 && fr_addr[0] == 8'h01, "R7", "first frame address", fr_addr[0], 1);
      chk(fr_addr[1] == 8'h02, "R7", "second frame address", fr_addr[1], 2);
      chk(fr_ok[0] && fr_ok[1], "R5", "check fields of both frames", fr_ok[0] & fr_ok[1], 1);
      chk(xfer1 + xfer2 == 8, "R10", "bytes handed over", xfer1 + xfer2, 8);
      chk(rdy_viol == 0, "R10", "ready pulse violations", rdy_viol, 0);
   endtask

   task automatic t_stuffing();
      do_reset(1'b1);
      for (int k = 0; k < 6; k++) q1[k] = 8'hFF;
      q1[6] = 8'h7E; q1[7] = 8'h1F; q1[8] = 8'hF8;
      n1 = 9; en_mode = 1;
      wait_frames(1, 3000);
      chk_payload1("R6");
      chk(nstuff > 0, "R6", "stuffed zeros removed", nstuff, 1);
      chk(maxrun <= 6, "R6", "longest ones run", maxrun, 6);
      chk(fr_ok[0], "R5", "check field after stuffing", fr_ok[0], 1);
   endtask

   task automatic t_max_len();
      do_reset(1'b1);
      for (int k = 0; k < 1030; k++) q1[k] = 8'(k * 7 + 3);
      n1 = 1030; en_mode = 1;
      wait_frames(2, 30000);
      chk(nfr == 2 && fr_len[0] == 1024, "R8", "first frame at payload limit", fr_len[0], 1024);
      chk(fr_len[1] == 6, "R8", "remainder frame length", fr_len[1], 6);
      chk(fr_ok[0] && fr_ok[1], "R5", "check fields of long frames", fr_ok[0] & fr_ok[1], 1);
      chk_payload1("R3");
   endtask

   task automatic t_gated();
      do_reset(1'b1);
      for (int k = 0; k < 5; k++) q1[k] = 8'(8'h5A ^ k);
      n1 = 5; en_mode = 2;
      wait_frames(1, 6000);
      en_mode = 0;
      repeat (4) @(negedge clk);
      chk(strobes == en_cnt, "R9", "strobes versus enabled cycles", strobes, en_cnt);
      chk(nfr == 1 && fr_ok[0], "R9", "frame under sparse enable", nfr, 1);
      chk_payload1("R9");
      chk(rdy_viol == 0, "R10", "ready outside enabled cycles", rdy_viol, 0);
   endtask

   task automatic t_scrambled();
      do_reset(1'b0);
      for (int k = 0; k < 6; k++) q1[k] = 8'(8'h10 * k + 9);
      n1 = 6; en_mode = 1;
      wait_frames(1, 3000);
      chk(nfr == 1 && fr_ok[0], "R11", "descrambled frame intact", nfr, 1);
      chk_payload1("R11");
      chk(ndiff > 0, "R11", "line differs from framed bits", ndiff, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      n1 = 0; n2 = 0; i1 = 0; i2 = 0; en_mode = 0; cyc = 0;
      t_reset_state();
      t_idle();
      t_single_s1();
      t_single_s2();
      t_priority();
      t_stuffing();
      t_max_len();
      t_gated();
      t_scrambled();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule